// File: doc/BRIEF.md
# Mode-Switched Halfband Decimate-by-Two Filter

This block is a symmetric halfband FIR filter that halves the sample rate of a stream of signed samples. One set of hardware serves three radio standards plus a scale-only setting. A two-bit band select picks the coefficient set at run time. The delay line and the multipliers are sized for the longest response, order `ORDER`, with an 11-tap default. Shorter responses sit in the centre of that line, and their outer coefficients are zero.

Only the odd offsets from the centre carry coefficients. Each of those tap pairs is pre-added before its single multiply. The centre tap is a fixed scale of one half, so it needs no multiplier. The other even-offset taps are zero and are never read. The products are summed at full precision, then rounded and saturated to `OUT_W` bits. A change of band select flushes the filter and restarts the fill.

The sequencing is a small state machine with three states:
- `PH_PRIME` counts the accepted samples after reset or a mode change. Its exit transition fires on the `NTAP`-th sample, which produces an output and moves to `PH_SKIP`.
- `PH_SKIP` accepts one sample without an output. Its transition on the next accepted sample goes to `PH_TAKE`.
- `PH_TAKE` produces an output on its accepted sample. Its transition goes back to `PH_SKIP`.
- From any state, the mode-change transition returns to `PH_PRIME` with the fill count at zero.

Top module: `hbd_decim`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0 and `out_data` is 0. Reset also sets the applied mode to 0 and zeroes the delay line.
- R2: After a flush, an output is produced on accepted samples number NTAP, NTAP+2, NTAP+4 and so on. No other sample produces an output, and `out_valid` is never high in two consecutive cycles.
- R3: The output for a sample accepted at clock edge k is presented with `out_valid` high after edge k+3.
- R4: Let x[j] be the sample j positions older than the newest one, c = (NTAP-1)/2 and o = 2m+1. The output is round((16384·x[c] + Σm Cm·(x[c−o] + x[c+o])) / 32768), with Cm the signed 16-bit coefficient of pair m.
- R5: Coefficients (C0, C1, C2) by band select: 0 → (9672, −1832, 352); 1 → (9216, −1024, 0), a shorter response padded with zero; 2 → (9800, −1960, 352); 3 → (0, 0, 0), which leaves only the centre half-scale.
- R6: For band select 0 to 2, a constant input gives the same constant at the output once the line is full.
- R7: Rounding adds 16384 to the full-precision sum and then shifts it arithmetically right by 15. Halves therefore round upward, so 18.5 gives 19 and −18.5 gives −18.
- R8: The sum is kept at full width without overflow. A result above 2^(OUT_W−1)−1 or below −2^(OUT_W−1) is clamped to that limit.
- R9: A change of `band_sel` has four effects. The delay line is cleared. The sample offered in that cycle is dropped. Any result still in the pipeline is discarded. The fill count restarts, so no output appears until NTAP new samples have been accepted.
- R10: A cycle with `in_valid` low changes neither the delay line nor the phase, whatever `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| band_sel | input | 2 | Coefficient set select (0 to 3) |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | OUT_W | Signed, rounded and saturated output |

## Verification
The assertions assume two things about the inputs. First, `band_sel` is sampled only at clock edges, and a value that differs from the one seen at the previous edge is a mode change. Second, the mode applied after reset is 0, which is the reference the checker uses for its own fill count.

The stimulus keeps to these assumptions. It changes `band_sel` only between edges and holds it steady between changes. It presents a sample on the change cycle only to show that this sample is dropped. It also holds samples within the signed `IN_W` range, so every sum the bench predicts is one the hardware can represent before saturation.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 15;

    typedef enum logic [1:0] {
        PH_PRIME = 2'd0,
        PH_SKIP  = 2'd1,
        PH_TAKE  = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        MD_WIDE   = 2'd0,
        MD_MID    = 2'd1,
        MD_NARROW = 2'd2,
        MD_HALF   = 2'd3
    } mode_t;

    // Coefficient of odd-offset pair k (offset 2k+1 from the centre), Q15.
    function automatic logic [COEF_W-1:0] side_coef(input mode_t md, input int k);
        logic signed [COEF_W-1:0] c;
        c = '0;
        unique case (md)
            MD_WIDE: begin
                if (k == 0)      c = 16'sd9672;
                else if (k == 1) c = -16'sd1832;
                else if (k == 2) c = 16'sd352;
            end
            MD_MID: begin
                if (k == 0)      c = 16'sd9216;
                else if (k == 1) c = -16'sd1024;
            end
            MD_NARROW: begin
                if (k == 0)      c = 16'sd9800;
                else if (k == 1) c = -16'sd1960;
                else if (k == 2) c = 16'sd352;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hbd_tapline.sv
module hbd_tapline #(
    parameter int W    = 8,
    parameter int NTAP = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    shift,
    input  logic [W-1:0]            din,
    output logic [NTAP-1:0][W-1:0]  taps
);

    // taps[0] holds the newest sample.
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        logic [W-1:0] r;
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     r <= '0;
                else if (clr)   r <= '0;
                else if (shift) r <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     r <= '0;
                else if (clr)   r <= '0;
                else if (shift) r <= taps[i-1];
            end
        end
        assign taps[i] = r;
    end

endmodule

// File: rtl/hbd_coef_rom.sv
module hbd_coef_rom #(
    parameter int NPAIR = 3
) (
    input  hbd_pkg::mode_t                           md,
    output logic [NPAIR-1:0][hbd_pkg::COEF_W-1:0]    coef
);

    for (genvar k = 0; k < NPAIR; k++) begin : g_coef
        assign coef[k] = hbd_pkg::side_coef(md, k);
    end

endmodule

// File: rtl/hbd_mac.sv
module hbd_mac #(
    parameter int IN_W  = 8,
    parameter int NTAP  = 11,
    parameter int NPAIR = 3,
    parameter int ACC_W = 28
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  go,
    input  logic                                  kill,
    input  logic [NTAP-1:0][IN_W-1:0]             taps,
    input  logic [NPAIR-1:0][hbd_pkg::COEF_W-1:0] coef,
    output logic                                  acc_vld,
    output logic signed [ACC_W-1:0]               acc
);

    import hbd_pkg::*;

    localparam int CTR = (NTAP - 1) / 2;

    logic                    v1_q;
    logic [IN_W-1:0]         ctr_q;
    logic signed [ACC_W-1:0] prod [NPAIR];
    logic signed [ACC_W-1:0] ctr_ext;
    logic signed [ACC_W-1:0] sum;

    // Stage 1: symmetric pre-add of each odd-offset pair.
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam int LO = CTR - 2 * k - 1;
        localparam int HI = CTR + 2 * k + 1;
        logic [IN_W:0]           psum_q;
        logic signed [ACC_W-1:0] pa;
        logic signed [ACC_W-1:0] ca;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  psum_q <= '0;
            else if (go) psum_q <= {taps[LO][IN_W-1], taps[LO]} + {taps[HI][IN_W-1], taps[HI]};
        end

        assign pa      = {{(ACC_W-IN_W-1){psum_q[IN_W]}}, psum_q};
        assign ca      = {{(ACC_W-COEF_W){coef[k][COEF_W-1]}}, coef[k]};
        assign prod[k] = pa * ca;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q  <= 1'b0;
            ctr_q <= '0;
        end else begin
            v1_q <= go && !kill;
            if (go) ctr_q <= taps[CTR];
        end
    end

    // Stage 2: full-precision sum; the centre tap is a shift by COEF_FRAC-1.
    assign ctr_ext = {{(ACC_W-IN_W){ctr_q[IN_W-1]}}, ctr_q};

    always_comb begin
        sum = ctr_ext <<< (COEF_FRAC - 1);
        for (int k = 0; k < NPAIR; k++) begin
            sum = sum + prod[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_vld <= 1'b0;
            acc     <= '0;
        end else begin
            acc_vld <= v1_q && !kill;
            if (v1_q) acc <= sum;
        end
    end

endmodule

// File: rtl/hbd_rndsat.sv
module hbd_rndsat #(
    parameter int ACC_W = 28,
    parameter int OUT_W = 8,
    parameter int FRAC  = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    kill,
    input  logic                    acc_vld,
    input  logic signed [ACC_W-1:0] acc,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_data
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);

    logic signed [ACC_W-1:0] biased;
    logic signed [ACC_W-1:0] shr;
    logic [ACC_W-OUT_W:0]    top;
    logic                    in_range;
    logic [OUT_W-1:0]        clamped;

    assign biased   = acc + HALF;
    assign shr      = biased >>> FRAC;
    assign top      = shr[ACC_W-1:OUT_W-1];
    assign in_range = (&top) || !(|top);
    assign clamped  = in_range ? shr[OUT_W-1:0]
                               : {shr[ACC_W-1], {(OUT_W-1){~shr[ACC_W-1]}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= acc_vld && !kill;
            if (acc_vld) out_data <= clamped;
        end
    end

endmodule

// File: rtl/hbd_decim.sv
module hbd_decim #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8,
    parameter int ORDER = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       band_sel,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    import hbd_pkg::*;

    localparam int NTAP  = ORDER + 1;
    localparam int NPAIR = (ORDER / 2 + 1) / 2;
    localparam int CNT_W = $clog2(NTAP + 1);
    localparam int ACC_W = IN_W + COEF_W + $clog2(NPAIR + 1) + 2;

    mode_t                           mode_q;
    phase_t                          state_q, state_d;
    logic [CNT_W-1:0]                fill_q, fill_d;
    logic                            mode_chg;
    logic                            accept;
    logic                            take;
    logic                            take_q;
    logic [NTAP-1:0][IN_W-1:0]       taps;
    logic [NPAIR-1:0][COEF_W-1:0]    coef;
    logic                            acc_vld;
    logic signed [ACC_W-1:0]         acc;

    assign mode_chg = (band_sel != mode_q);
    assign accept   = in_valid && !mode_chg;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_PRIME;
            fill_q  <= '0;
            mode_q  <= MD_WIDE;
            take_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
            mode_q  <= mode_t'(band_sel);
            take_q  <= take;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        if (mode_chg) begin
            state_d = PH_PRIME;
            fill_d  = '0;
        end else if (in_valid) begin
            unique case (state_q)
                PH_PRIME: begin
                    if (fill_q == CNT_W'(NTAP - 1)) state_d = PH_SKIP;
                    else                            fill_d  = fill_q + 1'b1;
                end
                PH_SKIP:  state_d = PH_TAKE;
                PH_TAKE:  state_d = PH_SKIP;
                default:  state_d = PH_PRIME;
            endcase
        end
    end

    // Outputs of the sequencer.
    always_comb begin
        take = 1'b0;
        if (accept) begin
            unique case (state_q)
                PH_PRIME: take = (fill_q == CNT_W'(NTAP - 1));
                PH_SKIP:  take = 1'b0;
                PH_TAKE:  take = 1'b1;
                default:  take = 1'b0;
            endcase
        end
    end

    hbd_tapline #(
        .W    (IN_W),
        .NTAP (NTAP)
    ) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mode_chg),
        .shift (accept),
        .din   (in_data),
        .taps  (taps)
    );

    hbd_coef_rom #(
        .NPAIR (NPAIR)
    ) u_rom (
        .md   (mode_q),
        .coef (coef)
    );

    hbd_mac #(
        .IN_W  (IN_W),
        .NTAP  (NTAP),
        .NPAIR (NPAIR),
        .ACC_W (ACC_W)
    ) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (take_q),
        .kill    (mode_chg),
        .taps    (taps),
        .coef    (coef),
        .acc_vld (acc_vld),
        .acc     (acc)
    );

    hbd_rndsat #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .FRAC  (COEF_FRAC)
    ) u_rnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill      (mode_chg),
        .acc_vld   (acc_vld),
        .acc       (acc),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/hbd_chk.sv
module hbd_chk #(
    parameter int NTAP = 11
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] band_sel,
    input logic       in_valid,
    input logic       out_valid
);

    localparam int SW = $clog2(NTAP + 1) + 1;

    logic [1:0]    sel_prev;
    logic [SW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_prev <= '0;
            seen     <= '0;
        end else begin
            sel_prev <= band_sel;
            if (band_sel != sel_prev)                 seen <= '0;
            else if (in_valid && seen < SW'(NTAP))    seen <= seen + 1'b1;
        end
    end

    AST_DECIM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R2

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 4)); // R3

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (band_sel != sel_prev) |=> !out_valid); // R9

    AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen >= SW'(NTAP))); // R9

endmodule

bind hbd_decim hbd_chk #(.NTAP(NTAP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .band_sel  (band_sel),
    .in_valid  (in_valid),
    .out_valid (out_valid)
);

// File: tb/test_hbd_decim.sv
module test_hbd_decim;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 8;
    localparam int OUT_W = 8;
    localparam int ORDER = 10;
    localparam int NTAP  = ORDER + 1;
    localparam int CTR   = (NTAP - 1) / 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       band_sel = 2'd0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;

    typedef struct {
        int     val;
        longint due;
    } exp_t;

    exp_t   sb[$];
    int     hist[$];
    int     cur_mode = 0;
    int     checks = 0;
    int     failures = 0;
    int     out_cnt = 0;
    longint cyc = 0;
    string  tag = "R4";

    hbd_decim #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W),
        .ORDER (ORDER)
    ) i_hbd_decim (
        .clk       (clk),
        .rst_n     (rst_n),
        .band_sel  (band_sel),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Coefficient table from R5.
    function automatic int coef_of(input int m, input int k);
        case (m)
            0: return (k == 0) ? 9672 : (k == 1) ? -1832 : 352;
            1: return (k == 0) ? 9216 : (k == 1) ? -1024 : 0;
            2: return (k == 0) ? 9800 : (k == 1) ? -1960 : 352;
            default: return 0;
        endcase
    endfunction

    // Reference output from R4, R7 and R8.
    function automatic int ref_out();
        int n;
        int s;
        int r;
        n = hist.size();
        s = 16384 * hist[n-1-CTR];
        for (int k = 0; k < (ORDER / 2 + 1) / 2; k++) begin
            s += coef_of(cur_mode, k) * (hist[n-1-(CTR-2*k-1)] + hist[n-1-(CTR+2*k+1)]);
        end
        r = (s + 16384) >>> 15;
        if (r > 127)  r = 127;
        if (r < -128) r = -128;
        return r;
    endfunction

    task automatic drive(input int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v[IN_W-1:0];
        hist.push_back(v);
        if (hist.size() >= NTAP && ((hist.size() - NTAP) % 2 == 0))
            sb.push_back(exp_t'{ref_out(), cyc + 4});
    endtask

    task automatic gap();
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = IN_W'($urandom_range(0, 255));
    endtask

    task automatic set_mode(input int m, input bit with_sample);
        @(negedge clk);
        #1;
        if (m != cur_mode) begin
            sb.delete();
            hist.delete();
        end
        cur_mode = m;
        band_sel = m[1:0];
        in_valid = with_sample;
        in_data  = IN_W'($urandom_range(0, 255));
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                out_cnt++;
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected output", $signed(out_data), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check($signed(out_data) == e.val, tag, $signed(out_data), e.val);
                    check(cyc == e.due, "R3 latency", cyc, e.due);
                end
            end else if (sb.size() > 0 && sb[0].due == cyc) begin
                check(1'b0, "R2 missing output", 0, sb[0].val);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(out_data == '0, "R1 out_data in reset", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(out_data == '0, "R1 out_data after reset", out_data, 0);

        // R6: DC input passes unchanged.
        tag = "R6";
        for (int i = 0; i < 15; i++) drive(100);
        for (int i = 0; i < 15; i++) drive(-77);

        // R4 and R10: random samples with idle gaps carrying garbage.
        tag = "R4/R10";
        for (int i = 0; i < 60; i++) begin
            drive($urandom_range(0, 255) - 128);
            if ($urandom_range(0, 3) == 0) gap();
        end

        // R5 with R9: switch modes with a sample offered on the change cycle.
        tag = "R5";
        set_mode(1, 1'b1);
        for (int i = 0; i < 40; i++) drive($urandom_range(0, 255) - 128);
        set_mode(2, 1'b1);
        for (int i = 0; i < 40; i++) begin
            drive($urandom_range(0, 255) - 128);
            if (i % 5 == 0) gap();
        end

        // R7: centre-only set exposes rounding of halves.
        tag = "R7";
        set_mode(3, 1'b0);
        for (int i = 0; i < 13; i++) drive(37);
        for (int i = 0; i < 12; i++) drive(-37);

        // R8: extreme windows drive the sum past the output range.
        tag = "R8";
        set_mode(0, 1'b0);
        for (int s = 1; s <= NTAP; s++) drive((NTAP - s == 2 || NTAP - s == 8) ? -127 : 127);
        gap();
        set_mode(2, 1'b0);
        set_mode(0, 1'b0);
        for (int s = 1; s <= NTAP; s++) drive((NTAP - s == 2 || NTAP - s == 8) ? 127 : -128);
        gap();
        repeat (6) @(negedge clk);

        // R9: a change right after a completing sample kills the result in flight.
        tag = "R9";
        set_mode(1, 1'b0);
        for (int i = 0; i < NTAP; i++) drive($urandom_range(0, 255) - 128);
        set_mode(2, 1'b1);
        c0 = out_cnt;
        for (int i = 0; i < NTAP - 1; i++) drive($urandom_range(0, 255) - 128);
        gap();
        repeat (8) @(negedge clk);
        check(out_cnt == c0, "R9 no output before refill", out_cnt, c0);
        drive(5);
        gap();
        repeat (8) @(negedge clk);
        check(out_cnt == c0 + 1, "R9 output after refill", out_cnt, c0 + 1);

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R2 all expected outputs seen", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule